// File: doc/BRIEF.md
# Toggle-Output PWM Timer Channel

This block is a single timer channel that produces a periodic waveform on one output pin. A 24-bit up-counter advances on a timer tick. The tick comes either from an internal divide-by-two of the clock or from an external prescaler tick, and a select input picks between them. When counting starts, the counter begins from the load value. The pin changes level when the count reaches the compare value and again when the count runs past its all-ones maximum. The load value therefore sets the period, and the compare value sets where inside the period the second edge falls.

When the enable input rises, the counter is cleared and the pin takes the level of the invert input. The first tick after that loads the load value, and each later tick adds one. On overflow, a reload-mode input chooses between two behaviours: restart at the load value on the overflow tick itself, or wrap through zero and keep counting. Compare and overflow events each set a sticky status flag. A flag is cleared by pulsing its clear input. Each flag drives an interrupt request that is gated by its own enable. The live count is always visible on a read port, and the count at the most recent compare match is held in a capture register.

Top module: `pwm_toggle_timer`

## Requirements
- R1: A rising edge of `run_en` (high now, low in the previous cycle, with `rst` low) sets `count_q` to 0 and `pin_out` to the value of `inv` on the next clock edge.
- R2: With `tick_sel`=0, the running counter receives a tick every second clock. The first tick falls on the second edge after the start edge. With `tick_sel`=1, every clock with `presc_tick`=1 while running is a tick.
- R3: The first tick after a start loads `load_val` into the counter. Every later tick increments the count by one.
- R4: On a tick whose new count equals `cmp_val`, `pin_out` inverts, `cmp_flag` sets, and `capture_q` takes that count.
- R5: A tick taken while the count is 0xFFFFFF is an overflow: `pin_out` inverts and `ovf_flag` sets.
- R6: With `reload_mode`=1, the overflow tick loads `load_val`, so the pin pattern repeats every 0xFFFFFF − `load_val` + 1 ticks. With `reload_mode`=0, the count wraps to 0 and keeps incrementing.
- R7: When a compare match and an overflow happen on the same tick, `pin_out` inverts once and both flags set.
- R8: `cmp_irq` is `cmp_flag` AND `cmp_ie`, and `ovf_irq` is `ovf_flag` AND `ovf_ie`.
- R9: A one-cycle pulse on `clr_cmp` or `clr_ovf` clears only that flag. A flag being set in the same cycle wins over the clear.
- R10: While `run_en` is low, `count_q` and `pin_out` hold their values whatever the tick inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_sel | input | 1 | Tick source: 0 = clock/2, 1 = prescaler tick |
| presc_tick | input | 1 | External prescaler tick |
| run_en | input | 1 | Timer enable; rising edge starts the channel |
| inv | input | 1 | Initial pin level at start |
| reload_mode | input | 1 | 1 = reload on overflow, 0 = wrap through zero |
| cmp_ie | input | 1 | Compare interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| clr_cmp | input | 1 | Clear compare flag (pulse) |
| clr_ovf | input | 1 | Clear overflow flag (pulse) |
| load_val | input | 24 | Load value |
| cmp_val | input | 24 | Compare value |
| pin_out | output | 1 | Toggle output pin |
| count_q | output | 24 | Live counter value |
| capture_q | output | 24 | Count at the last compare match |
| cmp_flag | output | 1 | Sticky compare status |
| ovf_flag | output | 1 | Sticky overflow status |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Each table vector starts from reset and applies a fixed number of prescaler ticks. The tick counts are picked to stop just before a match, on a match, and just after one or two overflows. That separates a one-tick slip in the load or compare logic from a wrong toggle count. Each load/compare pair is run with both reload settings, which exposes any confusion between reloading and wrapping. A vector whose compare value equals the load value forces match and overflow onto the same tick, so a double toggle shows up as a wrong pin level. Directed runs cover the clock/2 tick cadence, interrupt gating, single-flag clearing, and holding while disabled.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int CW = 24;

    typedef enum logic {
        SRC_DIV2  = 1'b0,
        SRC_PRESC = 1'b1
    } tick_src_e;

    typedef struct packed {
        logic      inv;
        logic      reload;
        tick_src_e src;
    } tmr_cfg_t;

    typedef struct packed {
        logic match;
        logic wrap;
    } tmr_evt_t;

    function automatic logic toggle_req(tmr_evt_t e);
        return e.match | e.wrap;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import pwm_tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      running,
    input  tick_src_e src,
    input  logic      presc_tick,
    output logic      tick
);
    logic phase;

    always_ff @(posedge clk) begin
        if (rst || start)
            phase <= 1'b0;
        else if (running)
            phase <= ~phase;
    end

    always_comb begin
        if (src == SRC_PRESC)
            tick = running & presc_tick;
        else
            tick = running & phase;
    end

    // R2: the divided tick never fires on two consecutive cycles
    assert_div2_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && src == SRC_DIV2) |=> !(tick && src == SRC_DIV2));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W = pwm_tmr_pkg::CW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         tick,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count,
    output logic [W-1:0] nxt,
    output pwm_tmr_pkg::tmr_evt_t evt
);
    logic         first;
    logic [W:0]   sum;

    always_comb begin
        sum       = {1'b0, count} + {{W{1'b0}}, 1'b1};
        evt.wrap  = tick & ~first & sum[W];
        if (first || (evt.wrap && reload))
            nxt = load_val;
        else
            nxt = sum[W-1:0];
        evt.match = tick & (nxt == cmp_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            first <= 1'b0;
        end else if (start) begin
            count <= '0;
            first <= 1'b1;
        end else if (tick) begin
            count <= nxt;
            first <= 1'b0;
        end
    end

    // R1: start clears the counter
    assert_start_zero_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> count == '0);

    // R3: first tick after start loads the load value
    assert_first_load_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && first && !start) |=> count == $past(load_val));

    // R3: an ordinary tick increments by one
    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !first && !start && count != '1) |=> count == $past(count) + 1'b1);

    // R6: reload on overflow restarts at the load value
    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.wrap && reload && !start) |=> count == $past(load_val));

    // R6: free-run mode wraps through zero
    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.wrap && !reload && !start) |=> count == '0);

endmodule

// File: rtl/tmr_out_stat.sv
module tmr_out_stat #(
    parameter int W = pwm_tmr_pkg::CW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         inv,
    input  pwm_tmr_pkg::tmr_evt_t evt,
    input  logic [W-1:0] nxt,
    input  logic [W-1:0] cmp_val,
    input  logic         clr_cmp,
    input  logic         clr_ovf,
    input  logic         cmp_ie,
    input  logic         ovf_ie,
    output logic         pin,
    output logic [W-1:0] capture,
    output logic         cmp_flag,
    output logic         ovf_flag,
    output logic         cmp_irq,
    output logic         ovf_irq
);
    import pwm_tmr_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)
            pin <= 1'b0;
        else if (start)
            pin <= inv;
        else if (toggle_req(evt))
            pin <= ~pin;
    end

    always_ff @(posedge clk) begin
        if (rst)
            capture <= '0;
        else if (evt.match)
            capture <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (evt.match)    cmp_flag <= 1'b1;
            else if (clr_cmp) cmp_flag <= 1'b0;
            if (evt.wrap)     ovf_flag <= 1'b1;
            else if (clr_ovf) ovf_flag <= 1'b0;
        end
    end

    assign cmp_irq = cmp_flag & cmp_ie;
    assign ovf_irq = ovf_flag & ovf_ie;

    // R4: a match captures the compare value and flags it
    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        evt.match |=> (capture == $past(cmp_val)) && cmp_flag);

    // R5: overflow sets its flag
    assert_ovf_flag_R5: assert property (@(posedge clk) disable iff (rst)
        evt.wrap |=> ovf_flag);

    // R7: coincident events give exactly one inversion
    assert_single_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (evt.match && evt.wrap && !start) |=> pin != $past(pin));

    // R4: without an event or start the pin is steady
    assert_pin_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!start && !evt.match && !evt.wrap) |=> $stable(pin));

    // R9: clear without a new event drops the flag
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_cmp && !evt.match) |=> !cmp_flag);

endmodule

// File: rtl/pwm_toggle_timer.sv
module pwm_toggle_timer
    import pwm_tmr_pkg::*;
#(
    parameter int W = CW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_sel,
    input  logic         presc_tick,
    input  logic         run_en,
    input  logic         inv,
    input  logic         reload_mode,
    input  logic         cmp_ie,
    input  logic         ovf_ie,
    input  logic         clr_cmp,
    input  logic         clr_ovf,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    output logic         pin_out,
    output logic [W-1:0] count_q,
    output logic [W-1:0] capture_q,
    output logic         cmp_flag,
    output logic         ovf_flag,
    output logic         cmp_irq,
    output logic         ovf_irq
);
    logic     en_d;
    logic     start;
    logic     running;
    logic     tick;
    logic [W-1:0] nxt;
    tmr_evt_t evt;
    tmr_cfg_t cfg;

    always_ff @(posedge clk) begin
        if (rst) en_d <= 1'b0;
        else     en_d <= run_en;
    end

    assign start   = run_en & ~en_d;
    assign running = run_en & en_d;
    assign cfg     = '{inv: inv, reload: reload_mode, src: tick_src_e'(tick_sel)};

    tmr_tick_gen u_tick (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .running    (running),
        .src        (cfg.src),
        .presc_tick (presc_tick),
        .tick       (tick)
    );

    tmr_count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tick     (tick),
        .reload   (cfg.reload),
        .load_val (load_val),
        .cmp_val  (cmp_val),
        .count    (count_q),
        .nxt      (nxt),
        .evt      (evt)
    );

    tmr_out_stat #(.W(W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .inv      (cfg.inv),
        .evt      (evt),
        .nxt      (nxt),
        .cmp_val  (cmp_val),
        .clr_cmp  (clr_cmp),
        .clr_ovf  (clr_ovf),
        .cmp_ie   (cmp_ie),
        .ovf_ie   (ovf_ie),
        .pin      (pin_out),
        .capture  (capture_q),
        .cmp_flag (cmp_flag),
        .ovf_flag (ovf_flag),
        .cmp_irq  (cmp_irq),
        .ovf_irq  (ovf_irq)
    );

    // R1: pin takes the invert level after a start edge
    assert_pin_init_R1: assert property (@(posedge clk) disable iff (rst)
        (run_en && !en_d) |=> pin_out == $past(inv));

    // R10: disabled channel holds count and pin
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!run_en && en_d == 1'b0) |=> $stable(count_q) && $stable(pin_out));

endmodule

// File: tb/test_pwm_toggle_timer.sv
module test_pwm_toggle_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, tick_sel, presc_tick, run_en, inv, reload_mode;
    logic        cmp_ie, ovf_ie, clr_cmp, clr_ovf;
    logic [23:0] load_val, cmp_val;
    logic        pin_out, cmp_flag, ovf_flag, cmp_irq, ovf_irq;
    logic [23:0] count_q, capture_q;
    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_toggle_timer i_pwm_toggle_timer (
        .clk(clk), .rst(rst), .tick_sel(tick_sel), .presc_tick(presc_tick),
        .run_en(run_en), .inv(inv), .reload_mode(reload_mode),
        .cmp_ie(cmp_ie), .ovf_ie(ovf_ie), .clr_cmp(clr_cmp), .clr_ovf(clr_ovf),
        .load_val(load_val), .cmp_val(cmp_val), .pin_out(pin_out),
        .count_q(count_q), .capture_q(capture_q), .cmp_flag(cmp_flag),
        .ovf_flag(ovf_flag), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    typedef struct packed {
        logic [23:0] ld;
        logic [23:0] cp;
        logic        iv;
        logic        rl;
        logic [7:0]  n;
        logic [23:0] ecnt;
        logic        epin;
        logic        ecf;
        logic        eof;
        logic [23:0] ecap;
    } vec_t;

    // tick counts chosen around match and overflow points (R3 R4 R5 R6 R7)
    localparam vec_t VECS [9] = '{
        '{24'hFFFFF0, 24'hFFFFF3, 1'b0, 1'b1, 8'd4,  24'hFFFFF3, 1'b1, 1'b1, 1'b0, 24'hFFFFF3},
        '{24'hFFFFF0, 24'hFFFFF3, 1'b0, 1'b1, 8'd3,  24'hFFFFF2, 1'b0, 1'b0, 1'b0, 24'h000000},
        '{24'hFFFFF0, 24'hFFFFF3, 1'b1, 1'b1, 8'd17, 24'hFFFFF0, 1'b1, 1'b1, 1'b1, 24'hFFFFF3},
        '{24'hFFFFF0, 24'hFFFFF3, 1'b1, 1'b0, 8'd17, 24'h000000, 1'b1, 1'b1, 1'b1, 24'hFFFFF3},
        '{24'hFFFFF0, 24'hFFFFF3, 1'b1, 1'b0, 8'd18, 24'h000001, 1'b1, 1'b1, 1'b1, 24'hFFFFF3},
        '{24'hFFFFF0, 24'hFFFFF0, 1'b0, 1'b1, 8'd17, 24'hFFFFF0, 1'b0, 1'b1, 1'b1, 24'hFFFFF0},
        '{24'hFFFFF0, 24'hFFFFF0, 1'b0, 1'b1, 8'd1,  24'hFFFFF0, 1'b1, 1'b1, 1'b0, 24'hFFFFF0},
        '{24'hFFFFFE, 24'h000005, 1'b1, 1'b0, 8'd8,  24'h000005, 1'b1, 1'b1, 1'b1, 24'h000005},
        '{24'hFFFFF0, 24'hFFFFF8, 1'b0, 1'b1, 8'd33, 24'hFFFFF0, 1'b0, 1'b1, 1'b1, 24'hFFFFF8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick_sel = 1'b1; presc_tick = 1'b0; run_en = 1'b0;
        inv = 1'b0; reload_mode = 1'b0; cmp_ie = 1'b0; ovf_ie = 1'b0;
        clr_cmp = 1'b0; clr_ovf = 1'b0; load_val = '0; cmp_val = '0;
        step(2);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // reset state
        chk("R1 reset pin", pin_out, 0);
        chk("R1 reset count", count_q, 0);
        chk("R8 reset irq", {cmp_irq, ovf_irq, cmp_flag, ovf_flag}, 0);

        for (int v = 0; v < 9; v++) begin
            do_reset();
            load_val = VECS[v].ld; cmp_val = VECS[v].cp;
            inv = VECS[v].iv; reload_mode = VECS[v].rl;
            run_en = 1'b1;
            step(1);
            chk("R1 start pin", pin_out, VECS[v].iv);
            presc_tick = 1'b1;
            step(int'(VECS[v].n));
            presc_tick = 1'b0;
            chk("R3 R6 count", count_q, VECS[v].ecnt);
            chk("R4 R7 pin", pin_out, VECS[v].epin);
            chk("R4 cmp_flag", cmp_flag, VECS[v].ecf);
            chk("R5 ovf_flag", ovf_flag, VECS[v].eof);
            chk("R4 capture", capture_q, VECS[v].ecap);
        end

        // R2: clock/2 tick cadence
        do_reset();
        tick_sel = 1'b0; load_val = 24'hFFFFF0; cmp_val = 24'hFFFFF3;
        inv = 1'b1; reload_mode = 1'b1;
        run_en = 1'b1;
        step(1);
        chk("R1 count cleared", count_q, 0);
        chk("R1 pin invert", pin_out, 1);
        step(4);
        chk("R2 div2 count", count_q, 24'hFFFFF1);
        step(1);
        chk("R2 div2 idle cycle", count_q, 24'hFFFFF1);

        // R8: interrupt gating
        tick_sel = 1'b1; cmp_ie = 1'b1; ovf_ie = 1'b0;
        presc_tick = 1'b1;
        step(2);
        presc_tick = 1'b0;
        chk("R4 match pin", pin_out, 0);
        chk("R8 cmp_irq on", cmp_irq, 1);
        chk("R8 ovf_irq off", ovf_irq, 0);
        presc_tick = 1'b1;
        step(13);
        presc_tick = 1'b0;
        chk("R6 reload count", count_q, 24'hFFFFF0);
        chk("R5 overflow pin", pin_out, 1);
        chk("R8 ovf_irq masked", ovf_irq, 0);
        ovf_ie = 1'b1;
        step(1);
        chk("R8 ovf_irq on", ovf_irq, 1);

        // R9: clear one flag only
        clr_cmp = 1'b1;
        step(1);
        clr_cmp = 1'b0;
        chk("R9 cmp cleared", cmp_flag, 0);
        chk("R9 ovf kept", ovf_flag, 1);
        chk("R9 cmp_irq dropped", cmp_irq, 0);

        // R10: disabled channel ignores ticks
        run_en = 1'b0;
        presc_tick = 1'b1;
        step(5);
        presc_tick = 1'b0;
        chk("R10 count held", count_q, 24'hFFFFF0);
        chk("R10 pin held", pin_out, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule